// File: doc/BRIEF.md
# Divider Event Timer with Sticky Flag

This block is a free-running binary divider with a sticky event flag. On each input tick the divider advances by one. When a chosen stage of the divider carries out, a flag is latched. The flag stays set until software clears it or the divider is cleared. Two separate enables gate the flag onto two request outputs: an interrupt request and a request to leave hold mode. Arbitration of those requests and power control are handled elsewhere.

The whole block runs on one system clock, and the input rate is chosen with clock enables. In one setting an external sub-clock tick pulse drives the divider. In the other setting an internal prescaler divides the system clock by 2^PRE_BITS (128 by default) and drives the divider instead. A tap-select input chooses when the flag fires: either every 2^LO_TAP ticks (2048 by default), or when the full DIV_BITS chain wraps (16384 by default).

Top module: `div_event_timer`

## Requirements
- R1: After reset the flag, `irq` and `holdRel` are 0 and every divider stage is 0, so the first event needs a full tap period of ticks.
- R2: With `tapSel`=0, each input tick advances the divider by one, and the flag is 1 in the cycle after the 2^LO_TAP-th tick counted from zero.
- R3: With `tapSel`=1, the flag sets only on a carry out of the top stage (every 2^DIV_BITS ticks). A carry at stage LO_TAP alone leaves the flag at 0.
- R4: Once set, the flag stays at 1 through further ticks and overflows until it is cleared.
- R5: A one-cycle `flagClr` pulse clears the flag in the next cycle and leaves the divider count unchanged.
- R6: A one-cycle `divClr` pulse sets all divider stages to 0 and clears the flag in the next cycle.
- R7: `irq` is 1 exactly when the flag is 1 and `intEn` is 1.
- R8: `holdRel` is 1 exactly when the flag is 1 and `holdEn` is 1.
- R9: If an overflow occurs in the same cycle as `flagClr` or `divClr`, the flag ends up at 1. When the clear is `divClr`, the divider still restarts from 0.
- R10: With `srcSel`=1, the divider advances once every 2^PRE_BITS system clocks from the internal prescaler, and `subTick` is ignored. With `srcSel`=0, only `subTick` (a one-cycle enable) advances it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 1 | 0: sub-clock tick enable, 1: prescaled system clock |
| subTick | input | 1 | One-cycle enable pulse from the sub-clock |
| divClr | input | 1 | Clears the divider and the flag |
| flagClr | input | 1 | Clears the flag only |
| tapSel | input | 1 | 0: low tap (2^LO_TAP), 1: full chain (2^DIV_BITS) |
| intEn | input | 1 | Interrupt enable |
| holdEn | input | 1 | Hold-release enable |
| evtFlag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |
| holdRel | output | 1 | Hold-mode release request |

## Verification
A divider stage that is wrong, or a carry that is gated wrongly, does not show at the ports until the next event. The flag then rises early or late against an exact tick count, so the bench counts ticks from a known zero and samples the flag at the tick before and the tick after the expected one. A flag latch that loses a set in a clear collision, or drops the flag on its own, shows up one cycle after the stimulus on `evtFlag`, `irq` and `holdRel`. A prescaler of the wrong width shows as an interval between events that differs from 2^(PRE_BITS+LO_TAP) clocks.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  // Strobes passed from the control side to the datapath each cycle.
  typedef struct packed {
    logic tick;      // divider advance enable
    logic wipe;      // return all stages to zero
    logic flagDrop;  // request to clear the event flag
  } dtmr_strobe_t;

endpackage

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int PRE_BITS = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcSel,
  input  logic         subTick,
  input  logic         divClr,
  input  logic         flagClr,
  output dtmr_strobe_t strb
);

  logic [PRE_BITS-1:0] preCnt;
  logic                mainTick;

  // Free-running prescaler; not affected by divClr.
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign mainTick = &preCnt;

  always_comb begin
    strb.tick     = srcSel ? mainTick : subTick;
    strb.wipe     = divClr;
    strb.flagDrop = divClr | flagClr;
  end

endmodule

// File: rtl/dtmr_path.sv
module dtmr_path
  import dtmr_pkg::*;
#(
  parameter int DIV_BITS = 14,
  parameter int LO_TAP   = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  dtmr_strobe_t        strb,
  input  logic                tapSel,
  input  logic                intEn,
  input  logic                holdEn,
  output logic                evtFlag,
  output logic                irq,
  output logic                holdRel,
  output logic                ovf,
  output logic [DIV_BITS-1:0] cnt
);

  logic [DIV_BITS:0] carry;

  assign carry[0] = strb.tick;

  // One toggle stage per divider bit, carry rippling upward.
  for (genvar i = 0; i < DIV_BITS; i++) begin : g_stage
    assign carry[i+1] = carry[i] & cnt[i];
    always_ff @(posedge clk) begin
      if (!rstN)          cnt[i] <= 1'b0;
      else if (strb.wipe) cnt[i] <= 1'b0;
      else if (carry[i])  cnt[i] <= ~cnt[i];
    end
  end

  assign ovf = tapSel ? carry[DIV_BITS] : carry[LO_TAP];

  // Sticky flag: a set beats any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)              evtFlag <= 1'b0;
    else if (ovf)           evtFlag <= 1'b1;
    else if (strb.flagDrop) evtFlag <= 1'b0;
  end

  assign irq     = evtFlag & intEn;
  assign holdRel = evtFlag & holdEn;

endmodule

// File: rtl/div_event_timer.sv
module div_event_timer
  import dtmr_pkg::*;
#(
  parameter int DIV_BITS = 14,
  parameter int LO_TAP   = 11,
  parameter int PRE_BITS = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcSel,
  input  logic subTick,
  input  logic divClr,
  input  logic flagClr,
  input  logic tapSel,
  input  logic intEn,
  input  logic holdEn,
  output logic evtFlag,
  output logic irq,
  output logic holdRel
);

  dtmr_strobe_t        strb;
  logic                ovfEvt;
  logic [DIV_BITS-1:0] divCount;

  dtmr_ctrl #(.PRE_BITS(PRE_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .srcSel  (srcSel),
    .subTick (subTick),
    .divClr  (divClr),
    .flagClr (flagClr),
    .strb    (strb)
  );

  dtmr_path #(.DIV_BITS(DIV_BITS), .LO_TAP(LO_TAP)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .tapSel  (tapSel),
    .intEn   (intEn),
    .holdEn  (holdEn),
    .evtFlag (evtFlag),
    .irq     (irq),
    .holdRel (holdRel),
    .ovf     (ovfEvt),
    .cnt     (divCount)
  );

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int DIV_BITS = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                divClr,
  input logic                flagClr,
  input logic                intEn,
  input logic                holdEn,
  input logic                evtFlag,
  input logic                irq,
  input logic                holdRel,
  input logic                ovf,
  input logic [DIV_BITS-1:0] cnt
);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !flagClr && !divClr) |=> evtFlag);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !ovf) |=> !evtFlag);

  // R6
  div_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    divClr |=> (cnt == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> evtFlag);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtFlag) |-> $past(ovf));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intEn && evtFlag));

  // R8
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdRel |-> (holdEn && evtFlag));

endmodule

bind div_event_timer dtmr_chk #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .divClr  (divClr),
  .flagClr (flagClr),
  .intEn   (intEn),
  .holdEn  (holdEn),
  .evtFlag (evtFlag),
  .irq     (irq),
  .holdRel (holdRel),
  .ovf     (ovfEvt),
  .cnt     (divCount)
);

// File: tb/div_event_timer_tb.sv
`timescale 1ns/1ps
module div_event_timer_tb;

  localparam int DIV_BITS = 6;
  localparam int LO_TAP   = 3;
  localparam int PRE_BITS = 2;
  localparam int LO_N     = 1 << LO_TAP;
  localparam int HI_N     = 1 << DIV_BITS;
  localparam int MAIN_PER = 1 << (PRE_BITS + LO_TAP);

  logic clk = 1'b0;
  logic rstN, srcSel, subTick, divClr, flagClr, tapSel, intEn, holdEn;
  logic evtFlag, irq, holdRel;
  int   nChecks = 0;
  int   nFails  = 0;
  int   cyc     = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  div_event_timer #(.DIV_BITS(DIV_BITS), .LO_TAP(LO_TAP), .PRE_BITS(PRE_BITS)) u_dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .subTick(subTick),
    .divClr(divClr), .flagClr(flagClr), .tapSel(tapSel),
    .intEn(intEn), .holdEn(holdEn),
    .evtFlag(evtFlag), .irq(irq), .holdRel(holdRel)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseTick();
    subTick = 1'b1;
    @(negedge clk);
    subTick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) pulseTick();
  endtask

  task automatic clearDiv();
    divClr = 1'b1;
    @(negedge clk);
    divClr = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic waitRise(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (evtFlag) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic tReset();
    rstN = 1'b0; srcSel = 1'b0; subTick = 1'b0; divClr = 1'b0;
    flagClr = 1'b0; tapSel = 1'b0; intEn = 1'b1; holdEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flag in reset", evtFlag, 0);
    check("R1 irq in reset", irq, 0);
    check("R1 holdRel in reset", holdRel, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tLowTap();
    ticks(LO_N - 1);
    check("R1 no flag before first period", evtFlag, 0);
    pulseTick();
    check("R2 flag after low-tap period", evtFlag, 1);
    clearDiv();
    ticks(LO_N - 1);
    check("R2 no flag one tick short", evtFlag, 0);
    pulseTick();
    check("R2 flag on exact tick", evtFlag, 1);
  endtask

  task automatic tHighTap();
    tapSel = 1'b1;
    clearDiv();
    ticks(LO_N);
    check("R3 low carry ignored", evtFlag, 0);
    ticks(HI_N - LO_N - 1);
    check("R3 no flag one tick short", evtFlag, 0);
    pulseTick();
    check("R3 flag on full wrap", evtFlag, 1);
    tapSel = 1'b0;
  endtask

  task automatic tStickyAndClear();
    clearDiv();
    ticks(LO_N + 3);
    check("R4 flag held after more ticks", evtFlag, 1);
    ticks(LO_N);
    check("R4 flag held over second overflow", evtFlag, 1);
    clearFlag();
    check("R5 flagClr clears flag", evtFlag, 0);
    ticks(LO_N - 4);
    check("R5 count kept, no early flag", evtFlag, 0);
    pulseTick();
    check("R5 count kept, flag on schedule", evtFlag, 1);
  endtask

  task automatic tDivClr();
    ticks(3);
    clearDiv();
    check("R6 divClr clears flag", evtFlag, 0);
    ticks(LO_N - 1);
    check("R6 stages zeroed, no early flag", evtFlag, 0);
    pulseTick();
    check("R6 full period after divClr", evtFlag, 1);
  endtask

  task automatic tGates();
    intEn = 1'b0; holdEn = 1'b0; #1;
    check("R7 irq masked", irq, 0);
    check("R8 holdRel masked", holdRel, 0);
    intEn = 1'b1; #1;
    check("R7 irq enabled", irq, 1);
    check("R8 holdRel still masked", holdRel, 0);
    intEn = 1'b0; holdEn = 1'b1; #1;
    check("R7 irq masked again", irq, 0);
    check("R8 holdRel enabled", holdRel, 1);
    intEn = 1'b1;
    clearFlag();
    check("R7 irq off with flag clear", irq, 0);
    check("R8 holdRel off with flag clear", holdRel, 0);
  endtask

  task automatic tSetWins();
    clearDiv();
    ticks(LO_N - 1);
    subTick = 1'b1; flagClr = 1'b1;
    @(negedge clk);
    subTick = 1'b0; flagClr = 1'b0;
    check("R9 set beats flagClr", evtFlag, 1);
    clearFlag();
    ticks(LO_N - 1);
    check("R9 no flag before overflow", evtFlag, 0);
    subTick = 1'b1; divClr = 1'b1;
    @(negedge clk);
    subTick = 1'b0; divClr = 1'b0;
    check("R9 set beats divClr", evtFlag, 1);
    clearFlag();
    ticks(LO_N - 1);
    check("R9 divider restarted from zero", evtFlag, 0);
    pulseTick();
    check("R9 next event one period later", evtFlag, 1);
  endtask

  task automatic tSource();
    int t1, t2;
    srcSel = 1'b1; subTick = 1'b1;
    clearDiv();
    clearFlag();
    waitRise(t1);
    clearFlag();
    waitRise(t2);
    check("R10 prescaled event interval", t2 - t1, MAIN_PER);
    srcSel = 1'b0; subTick = 1'b0;
    clearDiv();
    repeat (4 * MAIN_PER) @(negedge clk);
    check("R10 prescaler ignored on sub source", evtFlag, 0);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tLowTap();
    tHighTap();
    tStickyAndClear();
    tDivClr();
    tGates();
    tSetWins();
    tSource();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule